// File: doc/BRIEF.md
# Scoreboard Out-of-Order Issue Controller

This block is an execution core with a fixed pool of identical arithmetic units that share one register file. Instructions arrive in program order through a valid/ready issue port. Each instruction carries an opcode, a destination register and one or two source registers. Once accepted, an instruction passes through four steps. It is issued to a free unit. It reads both operands through the register file's two read ports. It executes. It writes its result through the single write port. Each step may be held back by a central scoreboard so that no read-after-write, write-after-read or write-after-write ordering is broken.

Two fixed-priority arbiters manage the shared resources. The read arbiter hands the read-port pair to one ready unit per cycle. The write arbiter hands the write port to one finished unit per cycle. The lowest-numbered unit wins in both. Independent instructions may complete out of order, but the register contents after the core drains always equal those of strictly sequential execution. An observation port reads any register at any time. `idle_o` shows when no unit holds an instruction.

Top module: `sb_core`

## Requirements
- R1: Opcode encoding is 0 add (rs1+rs2), 1 subtract (rs1-rs2), 2 multiply (rs1*rs2, low DATA_W bits), 3 move (copy of rs1, rs2 ignored). All arithmetic wraps modulo 2^DATA_W.
- R2: After reset, register k holds the value k, `idle_o` is 1 and `issue_ready_o` is 1.
- R3: An instruction is accepted on a rising edge where `issue_valid_i` and `issue_ready_o` are both 1. `issue_ready_o` is 0 while all NALU units are occupied.
- R4: `issue_ready_o` is 0 while an accepted instruction that targets `issue_rd_i` has not yet written back (write-after-write stall at issue).
- R5: An instruction reads a source only after every earlier instruction that writes that source has written it (read-after-write).
- R6: A unit writes its result only after every earlier instruction that reads the old value of its destination has read it (write-after-read).
- R7: At most one unit reads operands per cycle. When several units are ready, the lowest-numbered one reads first.
- R8: At most one unit writes back per cycle. When several units are done, the lowest-numbered one writes first.
- R9: An isolated instruction with ready sources leaves `idle_o` low for exactly 3 edges after its accepting edge. For a multiply this is 3+MUL_EXTRA edges.
- R10: `obs_data_o` shows the current contents of register `obs_addr_i` combinationally.
- R11: A value written back on an edge can be read as an operand in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_valid_i | input | 1 | Instruction present |
| issue_op_i | input | 2 | Opcode (R1 encoding) |
| issue_rd_i | input | $clog2(NREG) | Destination register |
| issue_rs1_i | input | $clog2(NREG) | First source register |
| issue_rs2_i | input | $clog2(NREG) | Second source register |
| issue_ready_o | output | 1 | Instruction accepted when valid |
| obs_addr_i | input | $clog2(NREG) | Observation register index |
| obs_data_o | output | DATA_W | Observed register value |
| idle_o | output | 1 | No unit occupied |

## Verification
Ordering faults in the scoreboard show up only as register values. A missed read-after-write wait, or an early write over a value still to be read, leaves a wrong word that the observation port shows as soon as the core drains. These bugs are found by comparing all registers against a sequential model after each program. Arbitration and latency faults change no values, so they are exposed through `idle_o` timing. That timing is measured in exact edge counts from the last accepting edge, and a misordered or doubled port grant moves it by at least one cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_MUL = 2'd2, OP_MOV = 2'd3} op_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_EXEC, ST_WB} stage_e;
endpackage

// File: rtl/sb_prio_arb.sv
module sb_prio_arb #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // lowest index wins
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_alu.sv
module sb_alu import sb_pkg::*; #(
  parameter int unsigned DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_MUL:  y_o = a_i * b_i;
      default: y_o = a_i;
    endcase
  end
endmodule

// File: rtl/sb_regfile.sv
module sb_regfile #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned RA_W  = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RA_W-1:0]   ra0_i,
  input  logic [RA_W-1:0]   ra1_i,
  output logic [DATA_W-1:0] rd0_o,
  output logic [DATA_W-1:0] rd1_o,
  input  logic              we_i,
  input  logic [RA_W-1:0]   wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [RA_W-1:0]   oa_i,
  output logic [DATA_W-1:0] od_o
);
  logic [DATA_W-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem[i] <= DATA_W'(i);
      else if (we_i && wa_i == RA_W'(i))    mem[i] <= wd_i;
    end
  end

  assign rd0_o = mem[ra0_i];
  assign rd1_o = mem[ra1_i];
  assign od_o  = mem[oa_i];
endmodule

// File: rtl/sb_core.sv
module sb_core import sb_pkg::*; #(
  parameter int unsigned NALU      = 4,
  parameter int unsigned NREG      = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MUL_EXTRA = 3,
  localparam int unsigned RA_W     = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [1:0]        issue_op_i,
  input  logic [RA_W-1:0]   issue_rd_i,
  input  logic [RA_W-1:0]   issue_rs1_i,
  input  logic [RA_W-1:0]   issue_rs2_i,
  output logic              issue_ready_o,
  input  logic [RA_W-1:0]   obs_addr_i,
  output logic [DATA_W-1:0] obs_data_o,
  output logic              idle_o
);
  localparam int unsigned UID_W = (NALU > 1) ? $clog2(NALU) : 1;
  localparam int unsigned CNT_W = $clog2(MUL_EXTRA + 2);

  // per-unit scoreboard entries
  stage_e            st     [NALU];
  op_e               u_op   [NALU];
  logic [RA_W-1:0]   u_fi   [NALU];
  logic [RA_W-1:0]   u_fj   [NALU];
  logic [RA_W-1:0]   u_fk   [NALU];
  logic              u_usek [NALU];
  logic [UID_W-1:0]  u_qj   [NALU];
  logic [UID_W-1:0]  u_qk   [NALU];
  logic              u_qjv  [NALU];
  logic              u_qkv  [NALU];
  logic [DATA_W-1:0] u_a    [NALU];
  logic [DATA_W-1:0] u_b    [NALU];
  logic [DATA_W-1:0] u_res  [NALU];
  logic [DATA_W-1:0] alu_y  [NALU];
  logic [CNT_W-1:0]  u_cnt  [NALU];

  logic [NALU-1:0] busy, free, alloc, rd_req, rd_gnt, wr_req, wr_gnt, war_blk;

  // register result status
  logic [NREG-1:0]  pend;
  logic [UID_W-1:0] pend_uid [NREG];

  logic              issue_fire, wr_fire, iss_usek, iss_j_wait, iss_k_wait;
  logic [UID_W-1:0]  alloc_uid, wr_uid;
  logic [RA_W-1:0]   wr_addr, rd_a0, rd_a1;
  logic [DATA_W-1:0] wr_data, rd_d0, rd_d1;

  always_comb begin
    for (int u = 0; u < NALU; u++) begin
      busy[u]    = (st[u] != ST_IDLE);
      rd_req[u]  = (st[u] == ST_READ) && !u_qjv[u] && !(u_usek[u] && u_qkv[u]);
      war_blk[u] = 1'b0;
      for (int f = 0; f < NALU; f++) begin
        if (f != u && st[f] == ST_READ) begin
          // an unread source that does not wait on u still needs the old value
          if (!u_qjv[f] && u_fj[f] == u_fi[u]) war_blk[u] = 1'b1;
          if (u_usek[f] && !u_qkv[f] && u_fk[f] == u_fi[u]) war_blk[u] = 1'b1;
        end
      end
      wr_req[u] = (st[u] == ST_WB) && !war_blk[u];
    end
  end

  assign free = ~busy;

  sb_prio_arb #(.N(NALU)) alloc_arb_i (.req_i(free),   .gnt_o(alloc));
  sb_prio_arb #(.N(NALU)) rd_arb_i    (.req_i(rd_req), .gnt_o(rd_gnt));
  sb_prio_arb #(.N(NALU)) wr_arb_i    (.req_i(wr_req), .gnt_o(wr_gnt));

  always_comb begin
    alloc_uid = '0;
    wr_uid    = '0;
    wr_addr   = '0;
    wr_data   = '0;
    rd_a0     = '0;
    rd_a1     = '0;
    for (int u = 0; u < NALU; u++) begin
      if (alloc[u]) alloc_uid = UID_W'(u);
      if (wr_gnt[u]) begin
        wr_uid  = UID_W'(u);
        wr_addr = u_fi[u];
        wr_data = u_res[u];
      end
      if (rd_gnt[u]) begin
        rd_a0 = u_fj[u];
        rd_a1 = u_fk[u];
      end
    end
  end

  assign wr_fire       = |wr_gnt;
  assign issue_ready_o = (|free) && !pend[issue_rd_i];
  assign issue_fire    = issue_valid_i && issue_ready_o;
  assign idle_o        = ~|busy;
  assign iss_usek      = (issue_op_i != OP_MOV);
  // a producer writing back this cycle counts as done for the new entry
  assign iss_j_wait    = pend[issue_rs1_i] && !wr_gnt[pend_uid[issue_rs1_i]];
  assign iss_k_wait    = iss_usek && pend[issue_rs2_i] && !wr_gnt[pend_uid[issue_rs2_i]];

  sb_regfile #(.NREG(NREG), .DATA_W(DATA_W)) rf_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ra0_i (rd_a0),
    .ra1_i (rd_a1),
    .rd0_o (rd_d0),
    .rd1_o (rd_d1),
    .we_i  (wr_fire),
    .wa_i  (wr_addr),
    .wd_i  (wr_data),
    .oa_i  (obs_addr_i),
    .od_o  (obs_data_o)
  );

  for (genvar g = 0; g < NALU; g++) begin : g_alu
    sb_alu #(.DATA_W(DATA_W)) alu_i (
      .op_i(u_op[g]),
      .a_i (u_a[g]),
      .b_i (u_b[g]),
      .y_o (alu_y[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int u = 0; u < NALU; u++) begin
        st[u]     <= ST_IDLE;
        u_op[u]   <= OP_ADD;
        u_fi[u]   <= '0;
        u_fj[u]   <= '0;
        u_fk[u]   <= '0;
        u_usek[u] <= 1'b0;
        u_qj[u]   <= '0;
        u_qk[u]   <= '0;
        u_qjv[u]  <= 1'b0;
        u_qkv[u]  <= 1'b0;
        u_a[u]    <= '0;
        u_b[u]    <= '0;
        u_res[u]  <= '0;
        u_cnt[u]  <= '0;
      end
    end else begin
      for (int u = 0; u < NALU; u++) begin
        case (st[u])
          ST_READ: if (rd_gnt[u]) begin
            u_a[u]   <= rd_d0;
            u_b[u]   <= rd_d1;
            u_cnt[u] <= (u_op[u] == OP_MUL) ? CNT_W'(MUL_EXTRA) : '0;
            st[u]    <= ST_EXEC;
          end
          ST_EXEC: begin
            if (u_cnt[u] == '0) begin
              u_res[u] <= alu_y[u];
              st[u]    <= ST_WB;
            end else begin
              u_cnt[u] <= u_cnt[u] - 1'b1;
            end
          end
          ST_WB: if (wr_gnt[u]) st[u] <= ST_IDLE;
          default: ;
        endcase
        if (wr_fire && u_qjv[u] && u_qj[u] == wr_uid) u_qjv[u] <= 1'b0;
        if (wr_fire && u_qkv[u] && u_qk[u] == wr_uid) u_qkv[u] <= 1'b0;
        if (issue_fire && alloc[u]) begin
          st[u]     <= ST_READ;
          u_op[u]   <= op_e'(issue_op_i);
          u_fi[u]   <= issue_rd_i;
          u_fj[u]   <= issue_rs1_i;
          u_fk[u]   <= issue_rs2_i;
          u_usek[u] <= iss_usek;
          u_qj[u]   <= pend_uid[issue_rs1_i];
          u_qk[u]   <= pend_uid[issue_rs2_i];
          u_qjv[u]  <= iss_j_wait;
          u_qkv[u]  <= iss_k_wait;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend <= '0;
      for (int r = 0; r < NREG; r++) pend_uid[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_fire && wr_addr == RA_W'(r)) pend[r] <= 1'b0;
        if (issue_fire && issue_rd_i == RA_W'(r)) begin
          pend[r]     <= 1'b1;
          pend_uid[r] <= alloc_uid;
        end
      end
    end
  end
endmodule

// File: rtl/sb_core_chk.sv
module sb_core_chk #(
  parameter int unsigned NALU = 4,
  parameter int unsigned NREG = 8,
  localparam int unsigned RA_W = $clog2(NREG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            issue_valid_i,
  input logic            issue_ready_o,
  input logic [RA_W-1:0] issue_rd_i,
  input logic [NALU-1:0] busy,
  input logic [NALU-1:0] rd_req,
  input logic [NALU-1:0] rd_gnt,
  input logic [NALU-1:0] wr_req,
  input logic [NALU-1:0] wr_gnt,
  input logic [NREG-1:0] pend
);
  p_full_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&busy) |-> !issue_ready_o);

  p_waw_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && pend[issue_rd_i]) |-> !issue_ready_o);

  p_rd_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_gnt) && ((rd_gnt & ~rd_req) == '0));

  p_wr_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_gnt) && ((wr_gnt & ~wr_req) == '0));

  p_rd_any_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rd_req) |-> (|rd_gnt));

  for (genvar i = 0; i < NALU; i++) begin : g_prio
    localparam logic [NALU-1:0] LOWER = NALU'((1 << i) - 1);
    p_rd_prio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_gnt[i] |-> ((rd_req & LOWER) == '0));
    p_wr_prio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_gnt[i] |-> ((wr_req & LOWER) == '0));
    p_wb_frees_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_gnt[i] |=> !busy[i] || $past(issue_valid_i && issue_ready_o));
  end
endmodule

bind sb_core sb_core_chk #(.NALU(NALU), .NREG(NREG)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_valid_i(issue_valid_i),
  .issue_ready_o(issue_ready_o),
  .issue_rd_i   (issue_rd_i),
  .busy         (busy),
  .rd_req       (rd_req),
  .rd_gnt       (rd_gnt),
  .wr_req       (wr_req),
  .wr_gnt       (wr_gnt),
  .pend         (pend)
);

// File: tb/sb_core_tb_top.sv
module sb_core_tb_top;
  localparam int NREG = 8;
  localparam int DW   = 16;
  localparam int MX   = 3;
  localparam logic [1:0] ADD = 2'd0, SUB = 2'd1, MUL = 2'd2, MOV = 2'd3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          issue_valid_i = 1'b0;
  logic [1:0]    issue_op_i = '0;
  logic [2:0]    issue_rd_i = '0, issue_rs1_i = '0, issue_rs2_i = '0;
  logic          issue_ready_o;
  logic [2:0]    obs_addr_i = '0;
  logic [DW-1:0] obs_data_o;
  logic          idle_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mdl [NREG];

  always #4 clk_i = ~clk_i;

  sb_core #(.NALU(4), .NREG(NREG), .DATA_W(DW), .MUL_EXTRA(MX)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .issue_valid_i(issue_valid_i),
    .issue_op_i(issue_op_i), .issue_rd_i(issue_rd_i), .issue_rs1_i(issue_rs1_i),
    .issue_rs2_i(issue_rs2_i), .issue_ready_o(issue_ready_o),
    .obs_addr_i(obs_addr_i), .obs_data_o(obs_data_o), .idle_o(idle_o)
  );

  function automatic logic [DW-1:0] ref_op(logic [1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      ADD:     return a + b;
      SUB:     return a - b;
      MUL:     return a * b;
      default: return a;
    endcase
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // call at a negedge; returns at the negedge after the accepting edge
  task automatic do_issue(input logic [1:0] op, input int rd, input int rs1, input int rs2);
    issue_op_i    = op;
    issue_rd_i    = 3'(rd);
    issue_rs1_i   = 3'(rs1);
    issue_rs2_i   = 3'(rs2);
    issue_valid_i = 1'b1;
    #1;
    while (!issue_ready_o) begin
      @(negedge clk_i);
      #1;
    end
    @(negedge clk_i);
    issue_valid_i = 1'b0;
    mdl[rd] = ref_op(op, mdl[rs1], mdl[rs2]);
  endtask

  task automatic edges_to_idle(output int k);
    k = 0;
    #1;
    while (!idle_o) begin
      @(negedge clk_i);
      #1;
      k++;
    end
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < NREG; r++) begin
      obs_addr_i = 3'(r);
      #1;
      chk(req, int'(obs_data_o), int'(mdl[r]));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int k;
    void'($urandom(32'd1234));
    for (int r = 0; r < NREG; r++) mdl[r] = DW'(r);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 / R10: reset contents through observation port
    check_regs("R2_R10");
    chk("R2 idle", int'(idle_o), 1);
    chk("R2 ready", int'(issue_ready_o), 1);

    // R9: isolated latencies
    do_issue(ADD, 1, 2, 3); edges_to_idle(k); chk("R9 add", k, 3);
    do_issue(SUB, 2, 5, 1); edges_to_idle(k); chk("R9 sub", k, 3);
    do_issue(MOV, 3, 7, 6); edges_to_idle(k); chk("R9 mov", k, 3);
    do_issue(MUL, 4, 6, 7); edges_to_idle(k); chk("R9 mul", k, 3 + MX);
    check_regs("R1");

    // R5/R6: dependent sequence ordered by the scoreboard
    do_issue(ADD, 3, 1, 2);
    do_issue(MUL, 5, 3, 4);
    do_issue(SUB, 4, 2, 1);
    do_issue(MOV, 6, 3, 0);
    do_issue(ADD, 4, 3, 2);
    edges_to_idle(k);
    check_regs("R5_R6 seq");

    // R6: fast move must not overwrite r5 before the waiting add reads it
    do_issue(MUL, 1, 2, 3);
    do_issue(ADD, 4, 1, 5);
    do_issue(MOV, 5, 6, 0);
    edges_to_idle(k);
    check_regs("R6");

    // R7/R11: three readers wake on one write and serialise on the read ports
    do_issue(MUL, 1, 2, 3);
    do_issue(ADD, 4, 1, 0);
    do_issue(ADD, 5, 1, 2);
    do_issue(ADD, 6, 1, 3);
    edges_to_idle(k);
    chk("R7_R11 timing", k, 5 + MX);
    check_regs("R7");

    // R8: add finishing with the multiply loses the write port
    do_issue(MUL, 1, 2, 3);
    repeat (MX - 1) @(negedge clk_i);
    do_issue(ADD, 7, 5, 6);
    edges_to_idle(k);
    chk("R8 timing", k, 4);
    check_regs("R8");

    // R3: all units busy
    do_issue(MUL, 4, 0, 1);
    do_issue(MUL, 5, 1, 2);
    do_issue(MUL, 6, 2, 3);
    do_issue(MUL, 7, 3, 0);
    issue_op_i = ADD; issue_rd_i = 3'd1; issue_rs1_i = 3'd0; issue_rs2_i = 3'd0;
    issue_valid_i = 1'b1;
    #1;
    chk("R3 full", int'(issue_ready_o), 0);
    do_issue(ADD, 1, 0, 0);
    edges_to_idle(k);
    check_regs("R3");

    // R4: pending write to the same destination blocks issue
    do_issue(MUL, 2, 3, 4);
    issue_op_i = ADD; issue_rd_i = 3'd2; issue_rs1_i = 3'd5; issue_rs2_i = 3'd6;
    issue_valid_i = 1'b1;
    #1;
    chk("R4 stall", int'(issue_ready_o), 0);
    issue_rd_i = 3'd6;
    #1;
    chk("R4 other", int'(issue_ready_o), 1);
    do_issue(ADD, 2, 5, 6);
    edges_to_idle(k);
    check_regs("R4");

    // R1/R5/R6: constrained random programs
    for (int p = 0; p < 30; p++) begin
      for (int i = 0; i < 12; i++) begin
        do_issue(2'($urandom % 4), int'($urandom % NREG), int'($urandom % NREG),
                 int'($urandom % NREG));
        if ($urandom % 4 == 0) repeat ($urandom % 3) @(negedge clk_i);
      end
      edges_to_idle(k);
      check_regs("R1_R5_R6 rand");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule